// File: doc/BRIEF.md
# Double-Precision to Wrapping 32-bit Integer Converter

This block turns an IEEE-754 double-precision operand into a 32-bit signed integer. It truncates toward zero and keeps only the low 32 bits of the exact integer part, so large values wrap instead of clamping. This is the behaviour a dynamically typed scripting runtime expects when it coerces a number to a 32-bit integer.

Next to the integer, the block returns a four-bit condition nibble. Its zero flag says whether the conversion was exact in the scripting sense. A negative zero, for example, counts as not exact. The block also keeps a set of sticky exception flags that gather every event raised since reset.

The conversion logic is purely combinational and is followed by one register stage. A result therefore appears one clock after the operand is presented with its valid strobe. A flush control selects whether subnormal operands are first replaced by zero.

Top module: `f64_to_i32_wrap`

## Requirements
- R1: A finite operand whose truncated integer part lies in [-2^31, 2^31-1] gives that truncated value on `out_result` as a two's complement number. For example, 1.5 gives 1, -1.5 gives 0xFFFFFFFF and 42.0 gives 42.
- R2: A finite operand whose truncated magnitude is 2^31 or more is not clamped. `out_result` is the low 32 bits of the truncated value, negated modulo 2^32 when the sign is set. An unbiased exponent of 84 or more therefore gives 0, and 2^32+5 gives 5.
- R3: An operand of -0.0 gives a result of 0, raises no exception flag and clears the Z bit of `out_nzcv`.
- R4: `out_nzcv` is {N,Z,C,V} with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. N, C and V are always 0. Z is 1 only when the conversion raised no exception flag and the operand was not -0.0.
- R5: Exception flag encoding: bit 0 is invalid, bit 1 is inexact and bit 2 is subnormal-flushed. Invalid is raised for NaN, for infinity and for a truncated value outside [-2^31, 2^31-1]. Inexact is raised when non-zero fraction bits are discarded from a finite operand that is not flushed. Every raised flag is ORed into `out_flags`, and only reset clears them.
- R6: A NaN or infinite operand gives a result of 0 and raises invalid.
- R7: A subnormal operand with `in_flush` = 1 gives 0 and raises subnormal-flushed without inexact. With `in_flush` = 0 it gives 0 and raises inexact.
- R8: `out_valid` is `in_valid` delayed by one clock. The result and Z bit of an accepted operand appear on the outputs one clock after it is presented.
- R9: A cycle with `in_valid` = 0 leaves `out_result`, `out_nzcv` and `out_flags` unchanged, whatever the operand and flush inputs carry.
- R10: While `rst_n` is low, `out_valid`, `out_result`, `out_nzcv` and `out_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Double-precision operand |
| in_flush | input | 1 | Replace subnormal operands with zero |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | 32 | Wrapped truncated integer |
| out_nzcv | output | 4 | Condition nibble {N,Z,C,V} |
| out_flags | output | 3 | Sticky flags {flushed, inexact, invalid} |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and a 32-bit result. With these widths, every exponent region can be reached from real doubles. That includes pure fractions, the right-shift range, the exact -2^31 boundary, the left-shift range up to unbiased exponent 83, and the all-zero region from 84 upward. Random operands are concentrated on unbiased exponents from -4 to 95, so each run crosses both shifter paths and the overflow edge many times. Reset is pulsed every few vectors so that the sticky flags start empty again and each new flag stays visible.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO    = 2'd0,
      CLS_SUB     = 2'd1,
      CLS_NORM    = 2'd2,
      CLS_SPECIAL = 2'd3
   } f2i_cls_e;

   localparam int FLG_INVALID = 0;
   localparam int FLG_INEXACT = 1;
   localparam int FLG_FLUSHED = 2;
   localparam int FLG_W       = 3;

   localparam int NZCV_W = 4;
   localparam int NZCV_Z = 2;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify import f2i_pkg::*; #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W,
   localparam int UE_W  = EXP_W + 1
) (
   input  logic                   op_valid_unused_i,
   input  logic [OP_W-1:0]        op_i,
   input  logic                   flush_i,
   output logic                   sign_o,
   output f2i_cls_e               cls_o,
   output logic signed [UE_W-1:0] uexp_o,
   output logic [FRAC_W:0]        mant_o,
   output logic                   flushed_o
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max, exp_min, frac_zero;

   assign exp_f     = op_i[OP_W-2 -: EXP_W];
   assign frac_f    = op_i[FRAC_W-1:0];
   assign exp_max   = &exp_f;
   assign exp_min   = ~|exp_f;
   assign frac_zero = ~|frac_f;

   assign sign_o = op_i[OP_W-1];
   assign mant_o = {~exp_min, frac_f};
   assign uexp_o = $signed({1'b0, exp_f}) - $signed(UE_W'(BIAS));

   always_comb begin
      flushed_o = 1'b0;
      if (exp_max) begin
         cls_o = CLS_SPECIAL;
      end else if (exp_min && frac_zero) begin
         cls_o = CLS_ZERO;
      end else if (exp_min) begin
         if (flush_i) begin
            cls_o     = CLS_ZERO;
            flushed_o = 1'b1;
         end else begin
            cls_o = CLS_SUB;
         end
      end else begin
         cls_o = CLS_NORM;
      end
   end

   logic unused_ok;
   assign unused_ok = op_valid_unused_i;

endmodule

// File: rtl/f2i_rshift.sv
module f2i_rshift #(
   parameter int W    = 53,
   parameter int SH_W = 6
) (
   input  logic [W-1:0]    data_i,
   input  logic [SH_W-1:0] sh_i,
   output logic [W-1:0]    data_o,
   output logic            lost_o
);
   logic [SH_W:0][W-1:0] stg;
   logic [SH_W:0]        lst;

   assign stg[0] = data_i;
   assign lst[0] = 1'b0;

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int AMT = 1 << k;
      if (AMT < W) begin : g_part
         assign stg[k+1] = sh_i[k] ? (stg[k] >> AMT) : stg[k];
         assign lst[k+1] = lst[k] | (sh_i[k] & (|stg[k][AMT-1:0]));
      end else begin : g_full
         assign stg[k+1] = sh_i[k] ? '0 : stg[k];
         assign lst[k+1] = lst[k] | (sh_i[k] & (|stg[k]));
      end
   end

   assign data_o = stg[SH_W];
   assign lost_o = lst[SH_W];

endmodule

// File: rtl/f2i_lshift.sv
module f2i_lshift #(
   parameter int IN_W  = 53,
   parameter int OUT_W = 32,
   parameter int SH_W  = 5
) (
   input  logic [IN_W-1:0]  data_i,
   input  logic [SH_W-1:0]  sh_i,
   output logic [OUT_W-1:0] data_o
);
   logic [SH_W:0][OUT_W-1:0] stg;

   if (IN_W >= OUT_W) begin : g_trunc
      assign stg[0] = data_i[OUT_W-1:0];
      if (IN_W > OUT_W) begin : g_drop
         logic unused_hi;
         assign unused_hi = ^data_i[IN_W-1:OUT_W];
      end
   end else begin : g_ext
      assign stg[0] = {{(OUT_W-IN_W){1'b0}}, data_i};
   end

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int AMT = 1 << k;
      if (AMT < OUT_W) begin : g_part
         assign stg[k+1] = sh_i[k] ? (stg[k] << AMT) : stg[k];
      end else begin : g_full
         assign stg[k+1] = sh_i[k] ? '0 : stg[k];
      end
   end

   assign data_o = stg[SH_W];

endmodule

// File: rtl/f2i_core.sv
module f2i_core import f2i_pkg::*; #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int RES_W  = 32,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0]  op_i,
   input  logic             flush_i,
   output logic [RES_W-1:0] res_o,
   output logic [FLG_W-1:0] flags_o,
   output logic             exact_o
);
   localparam int MANT_W = FRAC_W + 1;
   localparam int UE_W   = EXP_W + 1;
   localparam int RSH_W  = $clog2(FRAC_W + 1);
   localparam int LSH_W  = $clog2(RES_W);
   localparam logic [RES_W-1:0] MIN_MAG = {1'b1, {(RES_W-1){1'b0}}};

   logic                   sign, flushed;
   f2i_cls_e               cls;
   logic signed [UE_W-1:0] uexp;
   logic [MANT_W-1:0]      mant;

   f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_valid_unused_i (1'b0),
      .op_i              (op_i),
      .flush_i           (flush_i),
      .sign_o            (sign),
      .cls_o             (cls),
      .uexp_o            (uexp),
      .mant_o            (mant),
      .flushed_o         (flushed)
   );

   int ue;
   assign ue = int'(uexp);

   // exponent regions: pure fraction, right shift, left shift, all bits above result
   logic below_one, in_right, in_left;
   assign below_one = (ue < 0);
   assign in_right  = !below_one && (ue <= FRAC_W);
   assign in_left   = (ue > FRAC_W) && ((ue - FRAC_W) < RES_W);

   logic [RSH_W-1:0] rsh_amt;
   logic [LSH_W-1:0] lsh_amt;
   assign rsh_amt = in_right ? RSH_W'(FRAC_W - ue) : '0;
   assign lsh_amt = in_left  ? LSH_W'(ue - FRAC_W) : '0;

   logic [MANT_W-1:0] rsh_data;
   logic              rsh_lost;
   logic [RES_W-1:0]  lsh_data, rmag, mag;

   f2i_rshift #(.W(MANT_W), .SH_W(RSH_W)) u_rsh (
      .data_i (mant),
      .sh_i   (rsh_amt),
      .data_o (rsh_data),
      .lost_o (rsh_lost)
   );

   f2i_lshift #(.IN_W(MANT_W), .OUT_W(RES_W), .SH_W(LSH_W)) u_lsh (
      .data_i (mant),
      .sh_i   (lsh_amt),
      .data_o (lsh_data)
   );

   if (MANT_W >= RES_W) begin : g_rtrunc
      assign rmag = rsh_data[RES_W-1:0];
      if (MANT_W > RES_W) begin : g_drop
         logic unused_hi;
         assign unused_hi = ^rsh_data[MANT_W-1:RES_W];
      end
   end else begin : g_rext
      assign rmag = {{(RES_W-MANT_W){1'b0}}, rsh_data};
   end

   assign mag = in_right ? rmag : (in_left ? lsh_data : '0);

   logic is_norm, ovf, lost;
   assign is_norm = (cls == CLS_NORM);
   // magnitude in [2^(RES_W-1), 2^RES_W) only fits when negative and exactly the minimum
   assign ovf  = is_norm && ((ue >= RES_W) ||
                             ((ue == RES_W - 1) && !(sign && (mag == MIN_MAG))));
   assign lost = is_norm && (below_one || (in_right && rsh_lost));

   assign res_o = is_norm ? (sign ? (~mag + RES_W'(1)) : mag) : '0;

   always_comb begin
      flags_o              = '0;
      flags_o[FLG_INVALID] = (cls == CLS_SPECIAL) || ovf;
      flags_o[FLG_INEXACT] = (cls == CLS_SUB) || lost;
      flags_o[FLG_FLUSHED] = flushed;
   end

   assign exact_o = ~(|flags_o) && !(sign && (cls == CLS_ZERO));

endmodule

// File: rtl/f64_to_i32_wrap.sv
module f64_to_i32_wrap import f2i_pkg::*; #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int RES_W  = 32,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_operand,
   input  logic              in_flush,
   output logic              out_valid,
   output logic [RES_W-1:0]  out_result,
   output logic [NZCV_W-1:0] out_nzcv,
   output logic [FLG_W-1:0]  out_flags
);
   if (EXP_W < 3) begin : g_bad_exp
      $error("EXP_W must be at least 3");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("FRAC_W must be at least 1");
   end
   if (RES_W < 2) begin : g_bad_res
      $error("RES_W must be at least 2");
   end
   if (EXP_W > 30) begin : g_big_exp
      $error("EXP_W must not exceed 30");
   end

   logic [RES_W-1:0] res_c;
   logic [FLG_W-1:0] flags_c;
   logic             exact_c;

   f2i_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_core (
      .op_i    (in_operand),
      .flush_i (in_flush),
      .res_o   (res_c),
      .flags_o (flags_c),
      .exact_o (exact_c)
   );

   logic             vld_q, exact_q;
   logic [RES_W-1:0] res_q;
   logic [FLG_W-1:0] sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         exact_q  <= 1'b0;
         res_q    <= '0;
         sticky_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            res_q    <= res_c;
            exact_q  <= exact_c;
            sticky_q <= sticky_q | flags_c;
         end
      end
   end

   assign out_valid  = vld_q;
   assign out_result = res_q;
   assign out_flags  = sticky_q;

   always_comb begin
      out_nzcv         = '0;
      out_nzcv[NZCV_Z] = exact_q;
   end

   // ---------------- assertions ----------------
   localparam logic [OP_W-1:0] NEG_ZERO = {1'b1, {(OP_W-1){1'b0}}};

   p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_flags) && $stable(out_nzcv)));

   p_sticky_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_flags & $past(out_flags)) == $past(out_flags)));

   p_special_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (&in_operand[OP_W-2 -: EXP_W]))
      |=> ((out_result == '0) && out_flags[FLG_INVALID] && !out_nzcv[NZCV_Z]));

   p_negzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_operand == NEG_ZERO))
      |=> ((out_result == '0) && !out_nzcv[NZCV_Z]));

endmodule

// File: tb/sim_f64_to_i32_wrap.sv
`timescale 1ns/1ps
module sim_f64_to_i32_wrap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_operand = '0;
   logic        in_flush = 1'b0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [3:0]  out_nzcv;
   logic [2:0]  out_flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [2:0] exp_sticky = '0;
   logic [31:0] last_res = '0;
   logic [3:0]  last_nzcv = '0;

   always #4 clk = ~clk;

   f64_to_i32_wrap u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
      .in_flush(in_flush), .out_valid(out_valid), .out_result(out_result),
      .out_nzcv(out_nzcv), .out_flags(out_flags)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model written from the requirements
   task automatic model(input logic [63:0] op, input logic fl,
                        output logic [31:0] r, output logic [2:0] f, output logic z);
      logic sgn; logic [10:0] ex; logic [51:0] fr;
      logic [63:0] mant, mag; int e; logic lost, inv;
      sgn = op[63]; ex = op[62:52]; fr = op[51:0];
      r = '0; f = '0;
      if (ex == 11'h7FF) begin
         f[0] = 1'b1;
      end else if (ex == 0) begin
         if (fr != 0) begin
            if (fl) f[2] = 1'b1; else f[1] = 1'b1;
         end
      end else begin
         e = int'(ex) - 1023;
         mant = {11'd0, 1'b1, fr};
         lost = 1'b0;
         if (e < 0) begin
            mag = 0; lost = 1'b1;
         end else if (e <= 52) begin
            mag  = mant >> (52 - e);
            lost = (mant & ((64'd1 << (52 - e)) - 64'd1)) != 0;
         end else if (e - 52 < 64) begin
            mag = mant << (e - 52);
         end else begin
            mag = 0;
         end
         if (e >= 63) inv = 1'b1;
         else inv = sgn ? (mag > 64'h8000_0000) : (mag > 64'h7FFF_FFFF);
         r = sgn ? (32'd0 - mag[31:0]) : mag[31:0];
         f[0] = inv; f[1] = lost;
      end
      z = (f == 3'b000) && (op != 64'h8000_0000_0000_0000);
   endtask

   task automatic apply(input string tag, input logic [63:0] op, input logic fl);
      logic [31:0] er; logic [2:0] ef; logic ez;
      model(op, fl, er, ef, ez);
      exp_sticky = exp_sticky | ef;
      @(negedge clk);
      in_valid = 1'b1; in_operand = op; in_flush = fl;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid R8"}, 64'(out_valid), 64'd1);
      chk({tag, " result R1 R2"}, 64'(out_result), 64'(er));
      chk({tag, " nzcv R4"}, 64'(out_nzcv), 64'({1'b0, ez, 2'b00}));
      chk({tag, " sticky R5"}, 64'(out_flags), 64'(exp_sticky));
      last_res = er; last_nzcv = {1'b0, ez, 2'b00};
   endtask

   task automatic idle_check;
      @(negedge clk);
      in_operand = 64'h7FF8_0000_0000_0001; in_flush = 1'b1;
      @(negedge clk);
      chk("idle valid R8", 64'(out_valid), 64'd0);
      chk("idle result R9", 64'(out_result), 64'(last_res));
      chk("idle nzcv R9", 64'(out_nzcv), 64'(last_nzcv));
      chk("idle sticky R9", 64'(out_flags), 64'(exp_sticky));
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("reset valid R10", 64'(out_valid), 64'd0);
      chk("reset outputs R10", {27'd0, out_result, out_nzcv, out_flags}, 64'd0);
      rst_n = 1'b1;
      exp_sticky = '0; last_res = '0; last_nzcv = '0;
   endtask

   function automatic logic [63:0] rand_op;
      logic [63:0] op; int sel;
      sel = int'($urandom_range(0, 99));
      op = {$urandom, $urandom};
      if (sel < 6)       op[62:52] = 11'h7FF;
      else if (sel < 12) op[62:52] = 11'h000;
      else if (sel < 15) op[62:0]  = '0;
      else               op[62:52] = 11'(1019 + $urandom_range(0, 99));
      return op;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      do_reset;
      apply("1.5 R1", 64'h3FF8_0000_0000_0000, 1'b0);
      apply("-1.5 R1", 64'hBFF8_0000_0000_0000, 1'b0);
      apply("42 exact R1 R4", 64'h4045_0000_0000_0000, 1'b0);
      idle_check;
      do_reset;
      apply("-2^31 exact R1", 64'hC1E0_0000_0000_0000, 1'b0);
      apply("-2^31-0.5 R1", 64'hC1E0_0000_0010_0000, 1'b0);
      apply("+0 R4", 64'h0000_0000_0000_0000, 1'b0);
      apply("-0 R3", 64'h8000_0000_0000_0000, 1'b0);
      apply("0.5 R5", 64'h3FE0_0000_0000_0000, 1'b0);
      do_reset;
      apply("subnormal flush R7", 64'h0000_0000_0000_0001, 1'b1);
      apply("subnormal noflush R7", 64'h8000_0000_0000_0001, 1'b0);
      idle_check;
      do_reset;
      apply("2^31 wrap R2", 64'h41E0_0000_0000_0000, 1'b0);
      apply("2^32+5 wrap R2", 64'h41F0_0000_0050_0000, 1'b0);
      apply("2^83+2^31 wrap R2", 64'h4520_0000_0000_0001, 1'b0);
      apply("2^84 zero R2", 64'h4530_0000_0000_0000, 1'b0);
      apply("-3e9 wrap R2", 64'hC1E6_5A0B_C000_0000, 1'b0);
      do_reset;
      apply("NaN R6", 64'h7FF8_0000_0000_0000, 1'b0);
      apply("-inf R6", 64'hFFF0_0000_0000_0000, 1'b1);
      idle_check;
      for (int i = 0; i < 600; i++) begin
         if (i % 6 == 0) do_reset;
         apply("random R1 R2 R5", rand_op(), 1'($urandom_range(0, 1)));
         if (i % 11 == 0) idle_check;
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule